// File: doc/BRIEF.md
# UART Interrupt Priority Identification

This block gathers the interrupt sources of one UART channel that sit below the receive and transmit levels. It latches each pending event and reports the most urgent one as a 6-bit identification code, together with a pending flag and a gated interrupt request. Three levels are handled here: a modem-status change (level 4), character-detect events that exist only in enhanced mode (level 5), and rising edges on the CTS or RTS pins (level 6). Levels 1 to 3 are built elsewhere. They arrive as a single pending input and a code, and they pre-empt everything in this block.

Event inputs are synchronous to `clk`. Detect and match inputs are one-cycle strobes. Modem delta flags and the CTS/RTS pin states are levels, and the block finds their edges itself. A latched level is visible on the identification output in the cycle after the clock edge that captured the event. Level 4 clears only when the modem status register is read. Levels 5 and 6 each clear only when an identification read happens while that level is the one being reported.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset and whenever nothing is pending, `irq_id` reads 6'b000001, and both `irq_pend` and `irq_req` are 0.
- R2: A 0-to-1 change on any bit of `msr_delta` while `ien_modem`=1 latches level 4, which reports 6'b000000. Level 4 stays latched through identification reads and clears only on `msr_rd`.
- R3: Level 5 reports 6'b010000. It is latched only while `enh_mode`=1 and `ien_char`=1, and by any of three events: `xoff_det` with `inband_fc_en`=1, `xoff2_match` with `spec_det_en`=1, or any bit of `spec_match` with `nine_bit_mode`=1.
- R4: An `isr_rd` in a cycle where level 5 is reported clears level 5.
- R5: A low-to-high transition on `cts_n` or `rts_n` while `ien_flow`=1 latches level 6, which reports 6'b100000. High-to-low transitions have no effect.
- R6: An `isr_rd` clears level 6 only when level 6 is the one being reported. An `isr_rd` that reports any other level leaves levels 5 and 6 latched.
- R7: The fixed priority order is `hi_pend` (which reports `hi_code`), then level 4, then level 5, then level 6.
- R8: When an event and a clearing read for the same level fall in the same cycle, the level remains latched.
- R9: `irq_req` equals `irq_pend` when `irq_out_en`=1, and it is 0 when `irq_out_en`=0.
- R10: An event whose level enable or qualifying condition is 0 latches nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hi_pend | input | 1 | Some level 1..3 source is pending |
| hi_code | input | 6 | Identification code of the pending level 1..3 source |
| msr_delta | input | 4 | Modem delta flags (levels) |
| ien_modem | input | 1 | Level 4 enable |
| ien_char | input | 1 | Level 5 enable |
| ien_flow | input | 1 | Level 6 enable |
| enh_mode | input | 1 | Enhanced mode active |
| inband_fc_en | input | 1 | In-band flow control on |
| spec_det_en | input | 1 | Special-character detection on |
| nine_bit_mode | input | 1 | 9-bit data mode |
| xoff_det | input | 1 | Valid XOFF received (strobe) |
| xoff2_match | input | 1 | Character matched XOFF2 (strobe) |
| spec_match | input | 4 | Special character 1..4 matched (strobes) |
| cts_n | input | 1 | CTS pin state, active low |
| rts_n | input | 1 | RTS pin state, active low |
| msr_rd | input | 1 | Modem status register read strobe |
| isr_rd | input | 1 | Identification register read strobe |
| irq_out_en | input | 1 | Interrupt output enable |
| irq_id | output | 6 | Identification code of the winning level |
| irq_pend | output | 1 | Some level is pending |
| irq_req | output | 1 | Gated interrupt request |

## Verification
A latch that is wrongly set or wrongly left set shows up one cycle after the capturing edge. It appears as the wrong code on `irq_id`, as a spurious `irq_pend`, or as a level that comes back after a read. A lower level that is hidden behind a higher one only becomes visible once the higher one is cleared. For that reason the sequence clears stacked levels one at a time and checks the code after each read. A read that clears the wrong level shows its error at the latest when that level would have been reported next.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int ID_W = 6;

  typedef enum logic [2:0] {
    LV_NONE,
    LV_HI,
    LV_MODEM,
    LV_CHAR,
    LV_FLOW
  } irq_lvl_e;

  localparam logic [ID_W-1:0] ID_NONE  = 6'b000001;
  localparam logic [ID_W-1:0] ID_MODEM = 6'b000000;
  localparam logic [ID_W-1:0] ID_CHAR  = 6'b010000;
  localparam logic [ID_W-1:0] ID_FLOW  = 6'b100000;

  // code reported for a winning level
  function automatic logic [ID_W-1:0] lvl_code(irq_lvl_e lvl, logic [ID_W-1:0] hi);
    case (lvl)
      LV_HI:    lvl_code = hi;
      LV_MODEM: lvl_code = ID_MODEM;
      LV_CHAR:  lvl_code = ID_CHAR;
      LV_FLOW:  lvl_code = ID_FLOW;
      default:  lvl_code = ID_NONE;
    endcase
  endfunction
endpackage

// File: rtl/irq_sticky.sv
module irq_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  // set dominates clear so a coincident event is kept
  always_ff @(posedge clk) begin
    if (!rst_n) q_o <= 1'b0;
    else        q_o <= set_i | (q_o & ~clr_i);
  end
endmodule

// File: rtl/irq_rise_det.sv
module irq_rise_det #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic [W-1:0] sig_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] prev_q;

  // tracks the input during reset as well, so no edge is invented at release
  always_ff @(posedge clk) prev_q <= sig_i;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign rise_o[i] = sig_i[i] & ~prev_q[i];
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
  import uart_irq_pkg::*;
(
  input  logic            hi_pend,
  input  logic [ID_W-1:0] hi_code,
  input  logic            l4_q,
  input  logic            l5_q,
  input  logic            l6_q,
  output irq_lvl_e        win_o,
  output logic [ID_W-1:0] id_o,
  output logic            pend_o
);
  always_comb begin
    if      (hi_pend) win_o = LV_HI;
    else if (l4_q)    win_o = LV_MODEM;
    else if (l5_q)    win_o = LV_CHAR;
    else if (l6_q)    win_o = LV_FLOW;
    else              win_o = LV_NONE;
  end

  assign id_o   = lvl_code(win_o, hi_code);
  assign pend_o = (win_o != LV_NONE);
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int MDELTA_W = 4,
  parameter int SPEC_N   = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hi_pend,
  input  logic [5:0]          hi_code,
  input  logic [MDELTA_W-1:0] msr_delta,
  input  logic                ien_modem,
  input  logic                ien_char,
  input  logic                ien_flow,
  input  logic                enh_mode,
  input  logic                inband_fc_en,
  input  logic                spec_det_en,
  input  logic                nine_bit_mode,
  input  logic                xoff_det,
  input  logic                xoff2_match,
  input  logic [SPEC_N-1:0]   spec_match,
  input  logic                cts_n,
  input  logic                rts_n,
  input  logic                msr_rd,
  input  logic                isr_rd,
  input  logic                irq_out_en,
  output logic [5:0]          irq_id,
  output logic                irq_pend,
  output logic                irq_req
);
  localparam int PIN_N = 2;

  logic [MDELTA_W-1:0] delta_rise;
  logic [PIN_N-1:0]    pin_rise;
  logic l4_set, l4_clr, l4_q;
  logic l5_set, l5_clr, l5_q;
  logic l6_set, l6_clr, l6_q;
  logic char_evt;
  irq_lvl_e win_lvl;

  irq_rise_det #(.W(MDELTA_W)) u_delta_rise (
    .clk(clk), .sig_i(msr_delta), .rise_o(delta_rise)
  );

  irq_rise_det #(.W(PIN_N)) u_pin_rise (
    .clk(clk), .sig_i({rts_n, cts_n}), .rise_o(pin_rise)
  );

  // level 5 qualifying events
  assign char_evt = (xoff_det & inband_fc_en)
                  | (xoff2_match & spec_det_en)
                  | ((|spec_match) & nine_bit_mode);

  assign l4_set = ien_modem & (|delta_rise);
  assign l5_set = ien_char & enh_mode & char_evt;
  assign l6_set = ien_flow & (|pin_rise);

  assign l4_clr = msr_rd;
  assign l5_clr = isr_rd & (win_lvl == LV_CHAR);
  assign l6_clr = isr_rd & (win_lvl == LV_FLOW);

  irq_sticky u_l4 (.clk(clk), .rst_n(rst_n), .set_i(l4_set), .clr_i(l4_clr), .q_o(l4_q));
  irq_sticky u_l5 (.clk(clk), .rst_n(rst_n), .set_i(l5_set), .clr_i(l5_clr), .q_o(l5_q));
  irq_sticky u_l6 (.clk(clk), .rst_n(rst_n), .set_i(l6_set), .clr_i(l6_clr), .q_o(l6_q));

  irq_prio_enc u_enc (
    .hi_pend(hi_pend), .hi_code(hi_code),
    .l4_q(l4_q), .l5_q(l5_q), .l6_q(l6_q),
    .win_o(win_lvl), .id_o(irq_id), .pend_o(irq_pend)
  );

  assign irq_req = irq_pend & irq_out_en;
endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       isr_rd,
  input logic       msr_rd,
  input logic       enh_mode,
  input logic       ien_flow,
  input logic       cts_n,
  input logic       hi_pend,
  input logic       irq_out_en,
  input logic [5:0] irq_id,
  input logic       irq_pend,
  input logic       irq_req,
  input logic       l4_q,
  input logic       l5_q,
  input logic       l5_set,
  input logic       l6_q,
  input logic       l6_set
);
  assert_idle_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_pend |-> irq_id == 6'b000001);

  assert_l4_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    l4_q && !msr_rd |=> l4_q);

  assert_l5_enh_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !enh_mode && !l5_q |=> !l5_q);

  assert_l5_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    l5_q && isr_rd && !hi_pend && !l4_q && !l5_set |=> !l5_q);

  assert_l6_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ien_flow && $rose(cts_n) |=> l6_q);

  assert_l6_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    l6_q && isr_rd && irq_id == 6'b100000 && !l6_set |=> !l6_q);

  assert_prio_R7: assert property (@(posedge clk) disable iff (!rst_n)
    l5_q && !hi_pend |-> irq_pend && irq_id != 6'b100000);

  assert_l5_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    l5_set |=> l5_q);

  assert_l6_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    l6_set |=> l6_q);

  assert_req_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_out_en |-> !irq_req);
endmodule

bind uart_irq_ident uart_irq_ident_chk u_chk (
  .clk(clk), .rst_n(rst_n), .isr_rd(isr_rd), .msr_rd(msr_rd),
  .enh_mode(enh_mode), .ien_flow(ien_flow), .cts_n(cts_n),
  .hi_pend(hi_pend), .irq_out_en(irq_out_en), .irq_id(irq_id),
  .irq_pend(irq_pend), .irq_req(irq_req), .l4_q(l4_q), .l5_q(l5_q),
  .l5_set(l5_set), .l6_q(l6_q), .l6_set(l6_set)
);

// File: tb/tb_uart_irq_ident.sv
module tb_uart_irq_ident;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       hi_pend;
  logic [5:0] hi_code;
  logic [3:0] msr_delta;
  logic       ien_modem, ien_char, ien_flow, enh_mode;
  logic       inband_fc_en, spec_det_en, nine_bit_mode;
  logic       xoff_det, xoff2_match;
  logic [3:0] spec_match;
  logic       cts_n, rts_n, msr_rd, isr_rd, irq_out_en;
  logic [5:0] irq_id;
  logic       irq_pend, irq_req;

  localparam logic [5:0] E_IDLE = 6'b000001;
  localparam logic [5:0] E_MOD  = 6'b000000;
  localparam logic [5:0] E_CHR  = 6'b010000;
  localparam logic [5:0] E_FLW  = 6'b100000;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  uart_irq_ident dut (
    .clk(clk), .rst_n(rst_n), .hi_pend(hi_pend), .hi_code(hi_code),
    .msr_delta(msr_delta), .ien_modem(ien_modem), .ien_char(ien_char),
    .ien_flow(ien_flow), .enh_mode(enh_mode), .inband_fc_en(inband_fc_en),
    .spec_det_en(spec_det_en), .nine_bit_mode(nine_bit_mode),
    .xoff_det(xoff_det), .xoff2_match(xoff2_match), .spec_match(spec_match),
    .cts_n(cts_n), .rts_n(rts_n), .msr_rd(msr_rd), .isr_rd(isr_rd),
    .irq_out_en(irq_out_en), .irq_id(irq_id), .irq_pend(irq_pend),
    .irq_req(irq_req)
  );

  // monitor: compares shortly after each edge against the scoreboard
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if ({irq_id, irq_pend, irq_req} !== e) begin
        fails++;
        $display("FAIL %s: id=%b pend=%b req=%b expected id=%b pend=%b req=%b",
                 t, irq_id, irq_pend, irq_req, e[7:2], e[1], e[0]);
      end
    end
  end

  // driver: inputs already set at negedge; expectation applies after this edge
  task automatic tick(input logic [5:0] id, input logic pend, input logic req, input string tag);
    @(posedge clk);
    exp_q.push_back({id, pend, req});
    tag_q.push_back(tag);
    @(negedge clk);
    msr_rd = 0; isr_rd = 0; xoff_det = 0; xoff2_match = 0; spec_match = '0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: id=%b expected run to finish", irq_id);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; hi_pend = 0; hi_code = '0; msr_delta = '0;
    ien_modem = 1; ien_char = 1; ien_flow = 1; enh_mode = 1;
    inband_fc_en = 1; spec_det_en = 0; nine_bit_mode = 0;
    xoff_det = 0; xoff2_match = 0; spec_match = '0;
    cts_n = 1; rts_n = 1; msr_rd = 0; isr_rd = 0; irq_out_en = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    tick(E_IDLE, 0, 0, "R1 reset state");

    // R2 modem change
    msr_delta = 4'b0001;           tick(E_MOD, 1, 1, "R2 set");
    isr_rd = 1;                    tick(E_MOD, 1, 1, "R2 isr read keeps");
    msr_rd = 1; msr_delta = '0;    tick(E_IDLE, 0, 0, "R2 msr read clears");

    // R3/R4 character events
    xoff_det = 1;                  tick(E_CHR, 1, 1, "R3 xoff");
    isr_rd = 1;                    tick(E_IDLE, 0, 0, "R4 clear");
    inband_fc_en = 0; xoff_det = 1; tick(E_IDLE, 0, 0, "R10 xoff unqualified");
    inband_fc_en = 1;
    spec_det_en = 1; xoff2_match = 1; tick(E_CHR, 1, 1, "R3 xoff2");
    isr_rd = 1;                    tick(E_IDLE, 0, 0, "R4 clear xoff2");
    nine_bit_mode = 1; spec_match = 4'b1000; tick(E_CHR, 1, 1, "R3 special 4");
    isr_rd = 1;                    tick(E_IDLE, 0, 0, "R4 clear special");
    enh_mode = 0; xoff_det = 1;    tick(E_IDLE, 0, 0, "R3 not enhanced");
    enh_mode = 1;

    // R5 flow pins
    cts_n = 0;                     tick(E_IDLE, 0, 0, "R5 falling ignored");
    cts_n = 1;                     tick(E_FLW, 1, 1, "R5 cts rise");
    rts_n = 0;                     tick(E_FLW, 1, 1, "R5 hold");
    rts_n = 1;                     tick(E_FLW, 1, 1, "R5 rts rise");

    // R7 priority stacking, R6 selective clearing
    xoff_det = 1;                  tick(E_CHR, 1, 1, "R7 l5 over l6");
    msr_delta = 4'b0010;           tick(E_MOD, 1, 1, "R7 l4 over l5");
    hi_pend = 1; hi_code = 6'b000110; tick(6'b000110, 1, 1, "R7 high pre-empts");
    hi_pend = 0;                   tick(E_MOD, 1, 1, "R7 back to l4");
    isr_rd = 1;                    tick(E_MOD, 1, 1, "R6 isr on l4");
    msr_rd = 1; msr_delta = '0;    tick(E_CHR, 1, 1, "R6 l5 survived");
    isr_rd = 1;                    tick(E_FLW, 1, 1, "R6 l6 survived");
    isr_rd = 1;                    tick(E_IDLE, 0, 0, "R6 clear l6");

    // R8 set during clear
    rts_n = 0;                     tick(E_IDLE, 0, 0, "R8 prep");
    rts_n = 1;                     tick(E_FLW, 1, 1, "R8 l6 set");
    rts_n = 0;                     tick(E_FLW, 1, 1, "R8 prep2");
    rts_n = 1; isr_rd = 1;         tick(E_FLW, 1, 1, "R8 l6 kept");
    isr_rd = 1;                    tick(E_IDLE, 0, 0, "R8 l6 cleared");
    msr_delta = 4'b0100;           tick(E_MOD, 1, 1, "R8 l4 set");
    msr_delta = '0;                tick(E_MOD, 1, 1, "R8 l4 hold");
    msr_rd = 1; msr_delta = 4'b1000; tick(E_MOD, 1, 1, "R8 l4 kept");
    msr_rd = 1; msr_delta = '0;    tick(E_IDLE, 0, 0, "R8 l4 cleared");

    // R9 output gate
    irq_out_en = 0; cts_n = 0;     tick(E_IDLE, 0, 0, "R9 prep");
    cts_n = 1;                     tick(E_FLW, 1, 0, "R9 gated");
    irq_out_en = 1;                tick(E_FLW, 1, 1, "R9 ungated");
    isr_rd = 1;                    tick(E_IDLE, 0, 0, "R9 clear");

    // R10 disabled levels
    ien_flow = 0; cts_n = 0;       tick(E_IDLE, 0, 0, "R10 prep");
    cts_n = 1;                     tick(E_IDLE, 0, 0, "R10 flow disabled");
    ien_flow = 1;
    ien_modem = 0; msr_delta = 4'b0001; tick(E_IDLE, 0, 0, "R10 modem disabled");
    msr_delta = '0; ien_modem = 1;
    ien_char = 0; xoff_det = 1;    tick(E_IDLE, 0, 0, "R10 char disabled");
    ien_char = 1;                  tick(E_IDLE, 0, 0, "R1 idle end");

    @(posedge clk); #2;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule